// File: doc/BRIEF.md
# Prescaled PWM Timer Channel

This block produces an edge-aligned pulse-width-modulated waveform from a single clock. A programmable prescaler slows the clock down to a counter tick. A main up-counter runs from zero to a programmable reload value on those ticks and then returns to zero. The output is high while the count is below a programmable compare threshold. Each return to zero raises a one-cycle update pulse.

Software programs the channel over a small write-only register bus. Writes to prescale, reload and compare land in shadow copies. The shadow copies move into the active copies only at the wrap, so a period in progress always finishes with the settings it started with. The prescale and reload values are written as the desired divisor or length minus one.

A two-state controller governs counting. In `ST_HALT` the counter and prescaler hold their values. In `ST_COUNT` they advance. The *start* transition (`ST_HALT` to `ST_COUNT`) is taken on the clock edge after the run bit reads 1. The *stop* transition (`ST_COUNT` to `ST_HALT`) is taken on the edge after the run bit reads 0.

Top module: `pwm_timer_chan`

## Requirements
- R1: A write takes place only on a clock edge with `wr_en` high. Address 0 is control: bit 0 is run and bit 1 is output enable. Address 1 is prescale, address 2 is reload and address 3 is compare. With `wr_en` low, the bus has no effect.
- R2: In `ST_COUNT` the counter advances once every (prescale+1) clock cycles.
- R3: One PWM period lasts (reload+1) counter ticks, which is (prescale+1)*(reload+1) clock cycles. Once per wrap, `update_evt` is high for one clock cycle, and in that cycle `count` is 0.
- R4: With output enable set, `pwm_out` is high exactly while `count` is below the active compare value. Each period therefore holds (prescale+1)*min(compare, reload+1) high cycles.
- R5: A compare value of 0 keeps `pwm_out` low for the whole period. A compare value above reload keeps it high for the whole period.
- R6: New prescale, reload and compare values take effect only from the update pulse that follows their write. The period in progress is unchanged.
- R7: With output enable clear, `pwm_out` stays low.
- R8: With run clear, the controller is in `ST_HALT`. In that state `count` holds its value and `update_evt` stays low. Setting run again resumes counting from the held value.
- R9: After reset, `count` is 0, `pwm_out` is low, `update_evt` is low and all registers are 0.
- R10: `count` never exceeds the active reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 control, 1 prescale, 2 reload, 3 compare) |
| wr_data | input | DATA_W | Write data |
| pwm_out | output | 1 | PWM waveform |
| update_evt | output | 1 | One-cycle pulse on each wrap |
| count | output | DATA_W | Current main counter value |

## Verification
A write is captured on the edge where `wr_en` is high. The active copy changes only on the wrap edge, and `update_evt` and the zero count appear on that same edge. The bench therefore ignores any update pulse visible at the first sample after a write. It then measures one full period from the next update pulse to the one after it, and compares both the period length and the high-cycle count with closed-form values. A change to the run bit reaches the controller one edge after capture, and the counter moves or freezes from the following edge. The bench skips two samples before checking that `count` is frozen. All outputs are sampled on the falling clock edge, half a cycle after the rising edge that updates them.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam int         CTRL_RUN  = 0;
    localparam int         CTRL_OE   = 1;

    // shadowed fields, stored at address (index + 1)
    localparam int FIELD_PSC = 0;
    localparam int FIELD_ARR = 1;
    localparam int FIELD_CMP = 2;
    localparam int NUM_FIELDS = 3;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         load,
    output logic         run_req,
    output logic         out_en,
    output logic [W-1:0] psc_act,
    output logic [W-1:0] arr_act,
    output logic [W-1:0] cmp_act
);
    logic [NUM_FIELDS-1:0][W-1:0] act_bus;
    logic                         run_q;
    logic                         oe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            oe_q  <= 1'b0;
        end else if (wr_en && wr_addr == ADDR_CTRL) begin
            run_q <= wr_data[CTRL_RUN];
            oe_q  <= wr_data[CTRL_OE];
        end
    end

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        localparam logic [1:0] FADDR = 2'(f + 1);
        logic [W-1:0] shadow_q;
        logic [W-1:0] active_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow_q <= '0;
                active_q <= '0;
            end else begin
                if (wr_en && wr_addr == FADDR) begin
                    shadow_q <= wr_data;
                end
                if (load) begin
                    active_q <= shadow_q;
                end
            end
        end

        assign act_bus[f] = active_q;
    end

    assign run_req = run_q;
    assign out_en  = oe_q;
    assign psc_act = act_bus[FIELD_PSC];
    assign arr_act = act_bus[FIELD_ARR];
    assign cmp_act = act_bus[FIELD_CMP];

    // R6: active settings move only on a wrap
    assert_active_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act_bus));
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    input  logic [W-1:0] psc_act,
    output logic         tick
);
    logic [W-1:0] div_q;

    assign tick = advance && (div_q == psc_act);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (advance) begin
            div_q <= tick ? '0 : div_q + 1'b1;
        end
    end

    // R2: divider phase stays inside the programmed range
    assert_div_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= psc_act);
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_req,
    input  logic         tick,
    input  logic [W-1:0] arr_act,
    output logic         advance,
    output logic         wrap,
    output logic [W-1:0] count,
    output logic         update_evt
);
    run_state_t   state_q;
    run_state_t   state_d;
    logic [W-1:0] count_q;
    logic         update_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (run_req)  state_d = ST_COUNT;
            ST_COUNT: if (!run_req) state_d = ST_HALT;
            default:  state_d = ST_HALT;
        endcase
    end

    assign advance = (state_q == ST_COUNT);
    assign wrap    = tick && (count_q == arr_act);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            update_q <= 1'b0;
        end else begin
            update_q <= wrap;
            if (tick) begin
                count_q <= wrap ? '0 : count_q + 1'b1;
            end
        end
    end

    assign count      = count_q;
    assign update_evt = update_q;

    assert_evt_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        update_evt |-> (count_q == '0));

    assert_count_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= arr_act);

    assert_halt_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |=> ($stable(count_q) && !update_q));
endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_out,
    output logic              update_evt,
    output logic [DATA_W-1:0] count
);
    logic              run_req;
    logic              out_en;
    logic [DATA_W-1:0] psc_act;
    logic [DATA_W-1:0] arr_act;
    logic [DATA_W-1:0] cmp_act;
    logic              advance;
    logic              tick;
    logic              wrap;

    pwm_regs #(.W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (wrap),
        .run_req (run_req),
        .out_en  (out_en),
        .psc_act (psc_act),
        .arr_act (arr_act),
        .cmp_act (cmp_act)
    );

    pwm_prescaler #(.W(DATA_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .psc_act (psc_act),
        .tick    (tick)
    );

    pwm_counter #(.W(DATA_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_req    (run_req),
        .tick       (tick),
        .arr_act    (arr_act),
        .advance    (advance),
        .wrap       (wrap),
        .count      (count),
        .update_evt (update_evt)
    );

    assign pwm_out = out_en && (count < cmp_act);

    assert_out_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !pwm_out);

    assert_cmp_zero_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_act == '0) |-> !pwm_out);

    assert_cmp_over_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && cmp_act > arr_act) |-> pwm_out);
endmodule

// File: tb/pwm_timer_chan_bench.sv
module pwm_timer_chan_bench;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          pwm_out;
    logic          update_evt;
    logic [DW-1:0] count;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_timer_chan #(.DATA_W(DW)) u_pwm_timer_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .pwm_out    (pwm_out),
        .update_evt (update_evt),
        .count      (count)
    );

    function automatic int exp_period(int psc, int arr);
        return (psc + 1) * (arr + 1);
    endfunction

    function automatic int exp_high(int psc, int arr, int cmp, bit oe);
        int lim;
        lim = (cmp < arr + 1) ? cmp : arr + 1;
        return oe ? (psc + 1) * lim : 0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = DW'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic setup(input int psc, input int arr, input int cmp, input bit oe);
        wr(2'd1, psc);
        wr(2'd2, arr);
        wr(2'd3, cmp);
        wr(2'd0, {30'd0, oe, 1'b1});
    endtask

    // Skip the current sample, find the next update pulse, then measure one period.
    task automatic measure(output int len, output int high, output int maxc);
        int guard;
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!update_evt && guard < 5000);
        len = 0;
        high = 0;
        maxc = 0;
        do begin
            len++;
            high += int'(pwm_out);
            if (int'(count) > maxc) maxc = int'(count);
            @(negedge clk);
        end while (!update_evt && len < 5000);
    endtask

    task automatic run_case(input int psc, input int arr, input int cmp, input bit oe,
                            input string tag);
        int len, high, maxc;
        setup(psc, arr, cmp, oe);
        measure(len, high, maxc);
        chk(len == exp_period(psc, arr), {tag, " period"}, len, exp_period(psc, arr));
        chk(high == exp_high(psc, arr, cmp, oe), {tag, " high"}, high,
            exp_high(psc, arr, cmp, oe));
        chk(maxc <= arr, "R10 count above reload", maxc, arr);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int len, high, maxc, held, bad;
        void'($urandom(32'h1234_5678));

        repeat (3) @(negedge clk);
        // R9: reset state
        chk(count == '0, "R9 count after reset", int'(count), 0);
        chk(pwm_out == 1'b0, "R9 pwm after reset", int'(pwm_out), 0);
        chk(update_evt == 1'b0, "R9 evt after reset", int'(update_evt), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(count == '0 && !update_evt, "R9 idle while halted", int'(count), 0);

        // R2/R3/R4: directed shapes
        run_case(3, 9, 5, 1'b1, "R2 R4 basic");
        run_case(0, 0, 1, 1'b1, "R3 single tick period");
        run_case(2, 4, 0, 1'b1, "R5 compare zero");
        run_case(1, 6, 9, 1'b1, "R5 compare above reload");
        run_case(1, 6, 7, 1'b1, "R5 compare at reload+1");
        run_case(2, 5, 3, 1'b0, "R7 output disabled");

        // R1: bus ignored without strobe
        setup(1, 7, 3, 1'b1);
        @(negedge clk);
        wr_addr = 2'd3;
        wr_data = DW'(6);
        repeat (3) @(negedge clk);
        measure(len, high, maxc);
        measure(len, high, maxc);
        chk(high == exp_high(1, 7, 3, 1'b1), "R1 write without strobe", high,
            exp_high(1, 7, 3, 1'b1));

        // R6: compare change mid-period waits for the wrap
        setup(1, 9, 3, 1'b1);
        measure(len, high, maxc);
        do @(negedge clk); while (!update_evt);
        @(negedge clk);
        wr(2'd3, 7);
        bad = 0;
        while (!update_evt) begin
            if (pwm_out != (int'(count) < 3)) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R6 old compare kept", bad, 0);
        len = 0;
        high = 0;
        do begin
            len++;
            high += int'(pwm_out);
            @(negedge clk);
        end while (!update_evt && len < 5000);
        chk(high == exp_high(1, 9, 7, 1'b1), "R6 new compare applied", high,
            exp_high(1, 9, 7, 1'b1));

        // R8: stop holds the count, resume continues
        setup(2, 7, 4, 1'b1);
        repeat (11) @(negedge clk);
        wr(2'd0, 2);
        repeat (2) @(negedge clk);
        held = int'(count);
        bad = 0;
        repeat (20) begin
            @(negedge clk);
            if (int'(count) != held || update_evt) bad++;
        end
        chk(bad == 0, "R8 count frozen while halted", bad, 0);
        wr(2'd0, 3);
        repeat (2) @(negedge clk);
        bad = 0;
        repeat (3) begin
            @(negedge clk);
            if (int'(count) == held) bad++;
        end
        chk(bad < 3, "R8 counting resumed", int'(count), held + 1);
        measure(len, high, maxc);
        chk(len == exp_period(2, 7), "R8 period after resume", len, exp_period(2, 7));

        // Random configurations
        for (int i = 0; i < 20; i++) begin
            int psc, arr, cmp;
            bit oe;
            psc = int'($urandom % 4);
            arr = int'($urandom % 16);
            cmp = int'($urandom % 20);
            oe  = ($urandom % 5) != 0;
            run_case(psc, arr, cmp, oe, "R3 R4 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule